// File: doc/BRIEF.md
# Tagged UART Receive FIFO

This block is the receive half of a fixed-format high-speed serial port: 8 data bits, no parity and one stop bit. It watches a serial input line with a clock enable that pulses 14 times per bit. Each received character goes into a 64-entry FIFO, together with two tags: one for a framing error and one for a break. A single 32-bit read word presents the oldest entry, or reports that the FIFO is empty. A read strobe removes that entry.

Two requests go to a neighbouring interrupt block. The first is a trigger request, raised when the fill level reaches a selectable threshold. The second is a timeout request, raised when characters wait in the FIFO while the line has been quiet for a selectable number of character times. Framing errors, breaks and overruns are also reported, each as a one-cycle event pulse. A programmable offset, counted in oversample ticks from the detected start edge, sets where the data bits are sampled.

Top module: `hsrx_tagged`

## Requirements
- R1: The read word carries the data byte in bits 7:0, the framing-error tag in bit 9 and the break tag in bit 10. Bit 8 is set when the FIFO is empty. Bits 31:11 are zero. An empty FIFO reads as 0x100.
- R2: A start bit is accepted only if the line is still low 7 ticks after the falling edge. A shorter low pulse stores nothing.
- R3: Data bit k (LSB first) is sampled `cfg_offset + 14*k` ticks after the start edge, and the stop bit 8 bit-times after data bit 0. Offsets from 8 to 27 are valid, and characters must be received correctly at offsets 16, 20 and 24.
- R4: A stop bit sampled low sets the framing-error tag (bit 9) on the stored character and pulses `ev_frame` for one cycle.
- R5: An all-zero character whose stop bit is low is stored with both bit 10 and bit 9 set, and pulses `ev_break` together with `ev_frame`. No new start bit is accepted until the line has been seen high, so a long break stores exactly one entry.
- R6: Characters are read back in arrival order, and `rx_level` gives the number of stored entries (0 to 64).
- R7: A character that completes while the FIFO holds 64 entries is dropped and pulses `ev_overrun`. This also applies when a read happens in the same cycle. The stored entries are not changed.
- R8: A read strobe while the FIFO is empty changes neither the level nor the order of later entries.
- R9: `trig_req` is high while `rx_level` is at or above the threshold selected by `cfg_trig`. The codes are 0=1, 1=4, 2=8, 3=16, 4=32 and 5=48 characters; codes 6 and 7 also select 48.
- R10: `cfg_tmo` code 0 disables the timeout. Codes 1, 2 and 3 raise `tmo_req` after 4, 8 and 16 character times (10 bits of 14 ticks each) with no receive activity, no push and no read while the FIFO is not empty. A read, a push or a new start bit restarts the count, and `tmo_req` is low whenever the FIFO is empty.
- R11: After reset the FIFO is empty, the read word is 0x100, and all requests and events are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample enable, 14 pulses per bit |
| rxd | input | 1 | Serial input line, idle high |
| cfg_offset | input | 5 | Data-bit sample offset in ticks from the start edge |
| cfg_trig | input | 3 | Trigger threshold code |
| cfg_tmo | input | 2 | Inactivity timeout code |
| rd_en | input | 1 | Pop the oldest entry (ignored when empty) |
| rd_data | output | 32 | Oldest entry with tags and empty flag |
| rx_level | output | 8 | Number of stored entries |
| trig_req | output | 1 | Fill level at or above threshold |
| tmo_req | output | 1 | Inactivity timeout request |
| ev_frame | output | 1 | Framing-error event pulse |
| ev_break | output | 1 | Break event pulse |
| ev_overrun | output | 1 | Overrun event pulse |

## Verification
The bench sends a short low glitch to check that the start-bit check rejects it; a receiver without that check would store a phantom 0xFF. It receives random bytes at three sample offsets, which exposes any error in where bits are sampled as corrupted data. It holds a break low well past a character time; a receiver that re-arms on a low line would store a stream of extra zero entries. It then fills the FIFO to 64, sweeps every threshold code at every level, and overruns the full FIFO; a wrong pointer wrap or dropped-entry handling shows up as a mismatch on drain. Finally it checks each timeout code just before and just after its character-time limit, so an off-by-a-character counter gives a request that is early or missing.

// File: rtl/hsrx_pkg.sv
package hsrx_pkg;

  typedef struct packed {
    logic       brk;
    logic       err;
    logic [7:0] data;
  } rx_entry_t;

  localparam int ENTRY_W    = $bits(rx_entry_t);
  localparam int FRAME_BITS = 10;

  // threshold in characters selected by the trigger code
  function automatic int trig_level(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return 48;
    endcase
  endfunction

  // inactivity window in character times, 0 = off
  function automatic int tmo_chars(input logic [1:0] code);
    case (code)
      2'd1:    return 4;
      2'd2:    return 8;
      2'd3:    return 16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/hsrx_sampler.sv
module hsrx_sampler
  import hsrx_pkg::*;
#(
  parameter int OSR   = 14,
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  input  logic [OFS_W-1:0] cfg_offset,
  output logic             push_o,
  output rx_entry_t        entry_o,
  output logic             busy_o
);

  localparam int HALF  = OSR / 2;
  localparam int CNT_W = $clog2(OSR + (1 << OFS_W));
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] HALF_P1 = CNT_W'(HALF + 1);
  localparam logic [CNT_W-1:0] OSR_M1  = CNT_W'(OSR - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  logic [1:0]       sync_q;
  st_t              st_q, st_d;
  logic [CNT_W-1:0] dn_q, dn_d;
  logic [7:0]       sh_q, sh_d;
  logic [2:0]       bit_q, bit_d;
  logic             armed_q, armed_d;
  logic             rxs;

  assign rxs = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_comb begin
    st_d    = st_q;
    dn_d    = dn_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    armed_d = armed_q;
    push_o  = 1'b0;
    if (tick) begin
      case (st_q)
        S_IDLE: begin
          if (rxs) begin
            armed_d = 1'b1;
          end else if (armed_q) begin
            st_d = S_START;
            dn_d = HALF_M1;
          end
        end
        S_START: begin
          if (dn_q != '0) begin
            dn_d = dn_q - 1'b1;
          end else if (rxs) begin
            st_d = S_IDLE;
          end else begin
            st_d  = S_DATA;
            dn_d  = CNT_W'(cfg_offset) - HALF_P1;
            bit_d = '0;
          end
        end
        S_DATA: begin
          if (dn_q != '0) begin
            dn_d = dn_q - 1'b1;
          end else begin
            sh_d  = {rxs, sh_q[7:1]};
            dn_d  = OSR_M1;
            bit_d = bit_q + 1'b1;
            if (bit_q == 3'd7) st_d = S_STOP;
          end
        end
        default: begin
          if (dn_q != '0) begin
            dn_d = dn_q - 1'b1;
          end else begin
            push_o  = 1'b1;
            st_d    = S_IDLE;
            armed_d = rxs;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      dn_q    <= '0;
      sh_q    <= '0;
      bit_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      dn_q    <= dn_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
      armed_q <= armed_d;
    end
  end

  assign entry_o.data = sh_q;
  assign entry_o.err  = ~rxs;
  assign entry_o.brk  = ~rxs & (sh_q == 8'h00);
  assign busy_o       = (st_q != S_IDLE);

endmodule

// File: rtl/hsrx_fifo.sv
module hsrx_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop_req,
  output logic [W-1:0]               rdata,
  output logic                       empty,
  output logic                       full,
  output logic                       pop_o,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign wr    = push & ~full;
  assign pop_o = pop_req & ~empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr)    wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (pop_o) rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (wr && !pop_o)      cnt_d = cnt_q + 1'b1;
    else if (!wr && pop_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign count = cnt_q;

endmodule

// File: rtl/hsrx_timeout.sv
module hsrx_timeout
  import hsrx_pkg::*;
#(
  parameter int OSR = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       busy,
  input  logic       empty,
  input  logic       restart,
  input  logic [1:0] cfg_tmo,
  output logic       tmo_req
);

  localparam int TW = $clog2(16 * FRAME_BITS * OSR + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  int            lim;

  assign lim = tmo_chars(cfg_tmo) * FRAME_BITS * OSR;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || busy || empty || (cfg_tmo == 2'd0)) cnt_d = '0;
    else if (tick && (int'(cnt_q) < lim))              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tmo_req = (cfg_tmo != 2'd0) & ~empty & (int'(cnt_q) >= lim);

endmodule

// File: rtl/hsrx_tagged.sv
module hsrx_tagged
  import hsrx_pkg::*;
#(
  parameter int OSR   = 14,
  parameter int DEPTH = 64,
  parameter int OFS_W = 5,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic             rxd,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic [2:0]       cfg_trig,
  input  logic [1:0]       cfg_tmo,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  output logic [LVL_W-1:0] rx_level,
  output logic             trig_req,
  output logic             tmo_req,
  output logic             ev_frame,
  output logic             ev_break,
  output logic             ev_overrun
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]          rst_sync_q;
  logic                rst_n_i;
  logic                s_push, s_busy, f_empty, f_full, f_pop;
  rx_entry_t           s_entry, f_head;
  logic [ENTRY_W-1:0]  f_rdata;
  logic [CW-1:0]       f_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  hsrx_sampler #(.OSR(OSR), .OFS_W(OFS_W)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .tick       (os_tick),
    .rxd        (rxd),
    .cfg_offset (cfg_offset),
    .push_o     (s_push),
    .entry_o    (s_entry),
    .busy_o     (s_busy)
  );

  hsrx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .push    (s_push),
    .wdata   (s_entry),
    .pop_req (rd_en),
    .rdata   (f_rdata),
    .empty   (f_empty),
    .full    (f_full),
    .pop_o   (f_pop),
    .count   (f_count)
  );

  hsrx_timeout #(.OSR(OSR)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .tick    (os_tick),
    .busy    (s_busy),
    .empty   (f_empty),
    .restart (s_push | f_pop),
    .cfg_tmo (cfg_tmo),
    .tmo_req (tmo_req)
  );

  assign f_head  = rx_entry_t'(f_rdata);
  assign rd_data = {21'd0, f_head.brk & ~f_empty, f_head.err & ~f_empty,
                    f_empty, f_head.data & {8{~f_empty}}};

  assign rx_level   = LVL_W'(f_count);
  assign trig_req   = (int'(f_count) >= trig_level(cfg_trig));
  assign ev_frame   = s_push & s_entry.err;
  assign ev_break   = s_push & s_entry.brk;
  assign ev_overrun = s_push & f_full;

endmodule

// File: rtl/hsrx_tagged_chk.sv
module hsrx_tagged_chk #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [31:0]      rd_data,
  input logic [LVL_W-1:0] rx_level,
  input logic             trig_req,
  input logic             tmo_req,
  input logic             ev_frame,
  input logic             ev_break,
  input logic             ev_overrun,
  input logic             push
);

  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_level) <= DEPTH);

  a_r1_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[8] == (rx_level == '0));

  a_r1_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[8] |-> (rd_data[10:9] == 2'b00) && (rd_data[7:0] == 8'h00));

  a_r7_overrun_full: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |-> int'(rx_level) == DEPTH);

  a_r5_break_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ev_break |-> ev_frame);

  a_r10_tmo_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_req |-> rx_level != '0);

  a_r9_trig_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    trig_req |-> rx_level != '0);

  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_level == '0 && !push) |=> rx_level == '0);

endmodule

bind hsrx_tagged hsrx_tagged_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .rx_level   (rx_level),
  .trig_req   (trig_req),
  .tmo_req    (tmo_req),
  .ev_frame   (ev_frame),
  .ev_break   (ev_break),
  .ev_overrun (ev_overrun),
  .push       (s_push)
);

// File: tb/hsrx_tagged_bench.sv
`timescale 1ns/1ps
module hsrx_tagged_bench;

  logic        clk, rst_n, os_tick, rxd, rd_en;
  logic [4:0]  cfg_offset;
  logic [2:0]  cfg_trig;
  logic [1:0]  cfg_tmo;
  logic [31:0] rd_data;
  logic [7:0]  rx_level;
  logic        trig_req, tmo_req, ev_frame, ev_break, ev_overrun;

  int n_checks = 0, n_fail = 0;
  int n_frame = 0, n_break = 0, n_over = 0;
  int x_frame = 0, x_break = 0, x_over = 0;
  logic [10:0] mq[$];
  bit done = 0;

  hsrx_tagged u_hsrx_tagged (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_offset(cfg_offset), .cfg_trig(cfg_trig), .cfg_tmo(cfg_tmo),
    .rd_en(rd_en), .rd_data(rd_data), .rx_level(rx_level),
    .trig_req(trig_req), .tmo_req(tmo_req), .ev_frame(ev_frame),
    .ev_break(ev_break), .ev_overrun(ev_overrun)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      if (ev_frame)   n_frame++;
      if (ev_break)   n_break++;
      if (ev_overrun) n_over++;
    end
  end

  function automatic int thr_of(input int c);
    case (c)
      0: return 1; 1: return 4; 2: return 8; 3: return 16; 4: return 32;
      default: return 48;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  // serial frame, LSB first, 14 clocks per bit
  task automatic send_raw(input logic [7:0] b, input logic stop, input int extra_low);
    @(negedge clk) rxd = 1'b0;
    repeat (14) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (14) @(negedge clk);
    end
    rxd = stop;
    repeat (14) @(negedge clk);
    if (!stop) repeat (extra_low) @(negedge clk);
    rxd = 1'b1;
    repeat (14) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop, input int extra_low);
    logic err, brk;
    err = ~stop;
    brk = ~stop & (b == 8'h00);
    if (err) x_frame++;
    if (brk) x_break++;
    if (mq.size() >= 64) x_over++;
    else mq.push_back({brk, err, 1'b0, b});
    send_raw(b, stop, extra_low);
  endtask

  task automatic read_word(output logic [31:0] w);
    @(negedge clk);
    w = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic drain(input string req);
    logic [31:0] w;
    logic [10:0] e;
    while (mq.size() > 0) begin
      e = mq.pop_front();
      read_word(w);
      check(req, w, {21'd0, e});
    end
    #1 check(req, {24'd0, rx_level}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5eed_0042));
    rst_n = 0; os_tick = 1; rxd = 1; rd_en = 0;
    cfg_offset = 5'd20; cfg_trig = 3'd1; cfg_tmo = 2'd0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11 rd_data", rd_data, 32'h100);
    check("R11 level", {24'd0, rx_level}, 0);
    check("R11 reqs", {30'd0, trig_req, tmo_req}, 0);
    check("R11 events", {29'd0, ev_frame, ev_break, ev_overrun}, 0);

    // R8 / R1 empty read
    read_word(w);
    check("R1 empty word", w, 32'h100);
    #1 check("R8 level after empty read", {24'd0, rx_level}, 0);

    // R2 short glitch
    @(negedge clk) rxd = 0;
    repeat (3) @(negedge clk);
    rxd = 1;
    repeat (200) @(negedge clk);
    check("R2 glitch ignored", {24'd0, rx_level}, 0);

    // R6 / R3 random bytes at three offsets
    for (int i = 0; i < 10; i++) send(8'($urandom), 1'b1, 0);
    #1 check("R6 level", {24'd0, rx_level}, 10);
    read_word(w);
    check("R8 head after empty read", w, {21'd0, mq.pop_front()});
    drain("R6 order");
    cfg_offset = 5'd16;
    for (int i = 0; i < 5; i++) send(8'($urandom), 1'b1, 0);
    drain("R3 offset 16");
    cfg_offset = 5'd24;
    send(8'h80, 1'b1, 0);
    send(8'h01, 1'b1, 0);
    for (int i = 0; i < 3; i++) send(8'($urandom), 1'b1, 0);
    drain("R3 offset 24");
    cfg_offset = 5'd20;

    // R4 framing error
    send(8'hA5, 1'b0, 0);
    check("R4 frame events", n_frame, x_frame);
    check("R4 no break", n_break, 0);
    drain("R4 tag");

    // R5 long break
    send(8'h00, 1'b0, 300);
    #1 check("R5 one entry", {24'd0, rx_level}, 1);
    check("R5 break events", n_break, x_break);
    check("R5 frame events", n_frame, x_frame);
    drain("R5 tag");

    // R9 threshold sweep while filling, then R7 overrun
    for (int lvl = 1; lvl <= 64; lvl++) begin
      send(8'($urandom), 1'b1, 0);
      for (int c = 0; c < 8; c++) begin
        @(negedge clk) cfg_trig = 3'(c);
        #1 check($sformatf("R9 code %0d level %0d", c, lvl),
                 {31'd0, trig_req}, {31'd0, (lvl >= thr_of(c))});
      end
    end
    send(8'h3C, 1'b1, 0);
    send(8'hC3, 1'b1, 0);
    #1 check("R7 level stays full", {24'd0, rx_level}, 64);
    check("R7 overrun events", n_over, x_over);
    drain("R7 kept entries");

    // R10 timeout codes
    cfg_tmo = 2'd1;
    send(8'h11, 1'b1, 0);
    repeat (400) @(negedge clk);
    check("R10 code1 early", {31'd0, tmo_req}, 0);
    repeat (250) @(negedge clk);
    check("R10 code1 fired", {31'd0, tmo_req}, 1);
    drain("R10 read");
    check("R10 empty clears", {31'd0, tmo_req}, 0);
    cfg_tmo = 2'd2;
    send(8'h22, 1'b1, 0);
    repeat (1000) @(negedge clk);
    check("R10 code2 early", {31'd0, tmo_req}, 0);
    repeat (250) @(negedge clk);
    check("R10 code2 fired", {31'd0, tmo_req}, 1);
    drain("R10 read");
    cfg_tmo = 2'd3;
    send(8'h33, 1'b1, 0);
    repeat (2100) @(negedge clk);
    check("R10 code3 early", {31'd0, tmo_req}, 0);
    repeat (300) @(negedge clk);
    check("R10 code3 fired", {31'd0, tmo_req}, 1);
    cfg_tmo = 2'd0;
    repeat (2500) @(negedge clk);
    check("R10 code0 off", {31'd0, tmo_req}, 0);
    drain("R10 read");

    check("R4 frame total", n_frame, x_frame);
    check("R7 overrun total", n_over, x_over);
    finish_run();
  end

endmodule